// File: doc/BRIEF.md
# DVFS Load-Level Switching Controller

This controller owns the operating point of a CPU clock that can run at one of four load levels. Each level has its own stored pair of settings: a source select and a divide ratio. A 2-bit current-level register picks which pair drives the clock. A host asks for a divide ratio. The controller looks through the four stored levels for one whose divider equals that ratio, then moves the current level there.

When the clock base runs at 1 GHz or more, a direct climb to level 0 from a slower level is unsafe while the supply voltage is still settling. In that case the controller first parks on level 1. It then holds level 1 for a programmable dwell before it writes level 0. This intermediate step is skipped when the dwell was already served, or when the requested target frequency is below 1 GHz.

A dwell counts as already served in two cases. The first is that level 1 was entered from level 2 or 3 and the dwell time has since elapsed. The second is that level 1 was entered from level 0.

When dynamic scaling is switched off, the clock takes its select and divider from a static pair of inputs, and every request is refused.

Top module: `dvfs_level_ctrl`

## Requirements
- R1: The settings of levels 0 and 1 are held in `lvl01_cfg`, and those of levels 2 and 3 in `lvl23_cfg`.
  - Levels 0 and 2 use bits 31:16 of their register. Levels 1 and 3 use bits 15:0.
  - Inside each 16-bit half, the divider is bits 15:13 and the source select is bits 10:9.
  - With dynamic scaling on, `act_div` and `act_sel` show the fields of the level in `cur_level`.
- R2: When `mode_cfg` bit 31 is 0, `act_sel` equals `static_sel` and `act_div` equals `static_div`, whatever the current level. The other bits of `mode_cfg` have no effect.
- R3: A request accepted while `mode_cfg` bit 31 is 0 raises `err` for one cycle after the accepting edge and leaves `cur_level` unchanged.
- R4: A request checks levels 0, 1, 2 and 3 in that order and selects the first level whose divider equals `req_div`. If no level matches, `err` pulses for one cycle and the level is unchanged. `err`, `done` and `busy` are never high together in pairs.
- R5: A request that resolves to the current level pulses `done` in the cycle after the accepting edge, without `busy` and without any level change.
- R6: Climbing to level 0 requires an intermediate step when three conditions hold: `fast_base` is 1, `fast_target` is 1, and the dwell is not served. The step works as follows:
  - `cur_level` becomes 1 and `busy` stays high for exactly `DWELL_TICKS` cycles.
  - `cur_level` then becomes 0 and `done` pulses in the cycle in which `busy` falls.
- R7: With `fast_base` at 1, entering level 1 from level 2 or 3 starts a dwell of `DWELL_TICKS` cycles.
  - A request for level 0 made before the dwell ends takes the intermediate step.
  - A request for level 0 made after the dwell ends goes directly to level 0.
  - Entering level 2 or 3 clears any served dwell.
- R8: With `fast_base` at 1, entering level 1 from level 0 marks the dwell as served. A later request for level 0 then goes directly to level 0, with `done` and no `busy`.
- R9: A fast-base request for level 0 with `fast_target` at 0 goes directly to level 0 and clears the served dwell. A later climb to level 0 from level 1 then takes the intermediate step, provided level 1 was re-entered with `fast_base` at 0.
- R10: With `fast_base` at 0, every matching request writes its level directly, with `done` and no `busy`, and the dwell state is left as it was.
- R11: While `busy` is high, requests are ignored: they cause no `err`, no level change and no effect on the final level 0.
- R12: After reset, `cur_level` is 0, `busy`, `done` and `err` are 0, and the dwell is not served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_cfg | input | 32 | Mode word; bit 31 enables dynamic scaling |
| lvl01_cfg | input | 32 | Settings of levels 0 (upper half) and 1 (lower half) |
| lvl23_cfg | input | 32 | Settings of levels 2 (upper half) and 3 (lower half) |
| static_sel | input | 2 | Source select used when dynamic scaling is off |
| static_div | input | 3 | Divider used when dynamic scaling is off |
| req_valid | input | 1 | Request strobe, sampled when not busy |
| req_div | input | 3 | Requested divide ratio |
| fast_base | input | 1 | Base frequency is at least 1 GHz |
| fast_target | input | 1 | Target frequency is at least 1 GHz |
| cur_level | output | 2 | Current load level |
| act_sel | output | 2 | Active source select |
| act_div | output | 3 | Active divider |
| busy | output | 1 | Intermediate dwell in progress |
| done | output | 1 | One-cycle pulse on the final level write |
| err | output | 1 | One-cycle pulse on a refused request |

## Verification
A corrupted dwell flag or dwell timer shows up at the ports on the next fast request for level 0.
- If the dwell is wrongly believed served, `cur_level` goes straight to 0 where `busy` should have risen.
- If the dwell is wrongly believed unserved, `busy` rises where a bare `done` was expected. In either case the difference is visible one cycle after the request.

A wrong level register or a wrong field decode shows on `act_sel` and `act_div` in that same cycle. A miscounted wait counter moves the falling edge of `busy` away from exactly `DWELL_TICKS` cycles, so the bench samples both sides of that edge.

// File: rtl/dvfs_level_ctrl.sv
module dvfs_level_ctrl #(
  parameter int DWELL_TICKS = 2000000,
  localparam int CW = $clog2(DWELL_TICKS + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] mode_cfg,
  input  logic [31:0] lvl01_cfg,
  input  logic [31:0] lvl23_cfg,
  input  logic [1:0]  static_sel,
  input  logic [2:0]  static_div,
  input  logic        req_valid,
  input  logic [2:0]  req_div,
  input  logic        fast_base,
  input  logic        fast_target,
  output logic [1:0]  cur_level,
  output logic [1:0]  act_sel,
  output logic [2:0]  act_div,
  output logic        busy,
  output logic        done,
  output logic        err
);

  localparam logic [CW-1:0] TOP = CW'(DWELL_TICKS - 1);

  function automatic logic [15:0] half_of(input logic [1:0] l,
                                          input logic [31:0] a,
                                          input logic [31:0] b);
    logic [31:0] w;
    w = l[1] ? b : a;
    return l[0] ? w[15:0] : w[31:16];
  endfunction

  logic [1:0]    lvl;
  logic          busy_q, done_q, err_q;
  logic          l1_ok, l1_armed;
  logic [CW-1:0] wait_cnt, tmr_cnt;
  logic [15:0]   cur_half;
  logic          hit;
  logic [1:0]    hit_lvl;

  wire dyn_on  = mode_cfg[31];
  wire expired = l1_ok || (l1_armed && tmr_cnt == '0);

  assign cur_half  = half_of(lvl, lvl01_cfg, lvl23_cfg);
  assign act_div   = dyn_on ? cur_half[15:13] : static_div;
  assign act_sel   = dyn_on ? cur_half[10:9]  : static_sel;
  assign cur_level = lvl;
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;

  always_comb begin
    logic [15:0] h;
    hit     = 1'b0;
    hit_lvl = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      h = half_of(2'(i), lvl01_cfg, lvl23_cfg);
      if (h[15:13] == req_div) begin
        hit     = 1'b1;
        hit_lvl = 2'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl      <= 2'd0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      l1_ok    <= 1'b0;
      l1_armed <= 1'b0;
      wait_cnt <= '0;
      tmr_cnt  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (l1_armed) begin
        if (tmr_cnt == '0) begin
          l1_armed <= 1'b0;
          l1_ok    <= 1'b1;
        end else begin
          tmr_cnt <= tmr_cnt - 1'b1;
        end
      end
      if (busy_q) begin
        if (wait_cnt == '0) begin
          lvl      <= 2'd0;
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          l1_ok    <= 1'b0;
          l1_armed <= 1'b0;
        end else begin
          wait_cnt <= wait_cnt - 1'b1;
        end
      end else if (req_valid) begin
        if (!dyn_on || !hit) begin
          err_q <= 1'b1;
        end else if (hit_lvl == lvl) begin
          done_q <= 1'b1;
        end else if (!fast_base) begin
          lvl    <= hit_lvl;
          done_q <= 1'b1;
        end else if (hit_lvl == 2'd1) begin
          lvl    <= 2'd1;
          done_q <= 1'b1;
          if (lvl == 2'd0) begin
            l1_ok    <= 1'b1;
            l1_armed <= 1'b0;
          end else begin
            l1_ok    <= 1'b0;
            l1_armed <= 1'b1;
            tmr_cnt  <= TOP;
          end
        end else if (hit_lvl == 2'd0) begin
          l1_ok    <= 1'b0;
          l1_armed <= 1'b0;
          if (!fast_target || expired) begin
            lvl    <= 2'd0;
            done_q <= 1'b1;
          end else begin
            lvl      <= 2'd1;
            busy_q   <= 1'b1;
            wait_cnt <= TOP;
          end
        end else begin
          lvl      <= hit_lvl;
          done_q   <= 1'b1;
          l1_ok    <= 1'b0;
          l1_armed <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/dvfs_level_ctrl_chk.sv
module dvfs_level_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] cur_level,
  input logic       busy,
  input logic       done,
  input logic       err
);

  assert_busy_parks_l1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cur_level == 2'd1);

  assert_busy_ends_l0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cur_level == 2'd0 && done));

  assert_err_keeps_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(cur_level));

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err, done, busy}));

  assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> (!err && (busy || done)));

endmodule

bind dvfs_level_ctrl dvfs_level_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_level(cur_level),
  .busy(busy), .done(done), .err(err)
);

// File: tb/dvfs_level_ctrl_tb_top.sv
module dvfs_level_ctrl_tb_top;

  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mode_cfg = 32'h8000_0000;
  logic [31:0] lvl01_cfg = 32'h2000_4200;
  logic [31:0] lvl23_cfg = 32'h8400_A600;
  logic [1:0]  static_sel = 2'd3;
  logic [2:0]  static_div = 3'd6;
  logic        req_valid = 1'b0;
  logic [2:0]  req_div = 3'd0;
  logic        fast_base = 1'b0;
  logic        fast_target = 1'b0;
  logic [1:0]  cur_level;
  logic [1:0]  act_sel;
  logic [2:0]  act_div;
  logic        busy, done, err;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dvfs_level_ctrl #(.DWELL_TICKS(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .lvl01_cfg(lvl01_cfg),
    .lvl23_cfg(lvl23_cfg), .static_sel(static_sel), .static_div(static_div),
    .req_valid(req_valid), .req_div(req_div), .fast_base(fast_base),
    .fast_target(fast_target), .cur_level(cur_level), .act_sel(act_sel),
    .act_div(act_div), .busy(busy), .done(done), .err(err)
  );

  // {req_div, err, level, sel, div}
  localparam logic [10:0] VEC [7] = '{
    {3'd2, 1'b0, 2'd1, 2'd1, 3'd2},
    {3'd5, 1'b0, 2'd3, 2'd3, 3'd5},
    {3'd4, 1'b0, 2'd2, 2'd2, 3'd4},
    {3'd7, 1'b1, 2'd2, 2'd2, 3'd4},
    {3'd1, 1'b0, 2'd0, 2'd0, 3'd1},
    {3'd0, 1'b1, 2'd0, 2'd0, 3'd1},
    {3'd3, 1'b1, 2'd0, 2'd0, 3'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [2:0] d, input logic fb, input logic ft);
    @(negedge clk);
    req_valid = 1'b1; req_div = d; fast_base = fb; fast_target = ft;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic direct(input string tag, input logic [2:0] d, input logic fb,
                        input logic ft, input int lvl);
    do_req(d, fb, ft);
    chk({tag, " done"}, done, 1);
    chk({tag, " busy"}, busy, 0);
    chk({tag, " level"}, cur_level, lvl);
  endtask

  task automatic stepped(input string tag);
    do_req(3'd1, 1'b1, 1'b1);
    chk({tag, " busy start"}, busy, 1);
    chk({tag, " parked l1"}, cur_level, 1);
    repeat (D - 1) @(negedge clk);
    chk({tag, " busy last"}, busy, 1);
    @(negedge clk);
    chk({tag, " busy end"}, busy, 0);
    chk({tag, " done end"}, done, 1);
    chk({tag, " level end"}, cur_level, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset level", cur_level, 0);
    chk("R12 reset busy", busy, 0);
    chk("R12 reset done", done, 0);
    chk("R12 reset err", err, 0);
    chk("R1 reset div", act_div, 1);

    for (int i = 0; i < 7; i++) begin
      do_req(VEC[i][10:8], 1'b0, 1'b0);
      chk("R4 err", err, int'(VEC[i][7]));
      chk("R4 done", done, int'(!VEC[i][7]));
      chk("R4 level", cur_level, int'(VEC[i][6:5]));
      chk("R1 sel", act_sel, int'(VEC[i][4:3]));
      chk("R1 div", act_div, int'(VEC[i][2:0]));
    end

    lvl23_cfg = 32'h8400_8600;
    do_req(3'd4, 1'b0, 1'b0);
    chk("R4 first match level", cur_level, 2);
    lvl23_cfg = 32'h8400_A600;
    direct("R10 slow base back", 3'd1, 1'b0, 1'b0, 0);

    direct("R5 same level", 3'd1, 1'b1, 1'b1, 0);

    mode_cfg = 32'h7FFF_FFFF;
    @(negedge clk);
    chk("R2 static sel", act_sel, 3);
    chk("R2 static div", act_div, 6);
    do_req(3'd2, 1'b0, 1'b0);
    chk("R3 err", err, 1);
    chk("R3 level", cur_level, 0);
    mode_cfg = 32'h8000_0000;
    @(negedge clk);
    chk("R1 dyn div back", act_div, 1);

    direct("R6 to l2", 3'd4, 1'b1, 1'b1, 2);
    do_req(3'd1, 1'b1, 1'b1);
    chk("R6 busy", busy, 1);
    do_req(3'd5, 1'b1, 1'b1);
    chk("R11 no err", err, 0);
    chk("R11 level held", cur_level, 1);
    chk("R11 busy held", busy, 1);
    repeat (D - 3) @(negedge clk);
    chk("R6 busy last", busy, 1);
    @(negedge clk);
    chk("R6 done", done, 1);
    chk("R11 final level", cur_level, 0);

    direct("R7 to l2", 3'd4, 1'b1, 1'b1, 2);
    direct("R7 arm l1", 3'd2, 1'b1, 1'b1, 1);
    stepped("R7 early");

    direct("R7 to l2 b", 3'd4, 1'b1, 1'b1, 2);
    direct("R7 arm l1 b", 3'd2, 1'b1, 1'b1, 1);
    repeat (2 * D) @(negedge clk);
    direct("R7 after dwell", 3'd1, 1'b1, 1'b1, 0);

    direct("R8 l1 from l0", 3'd2, 1'b1, 1'b1, 1);
    direct("R8 straight l0", 3'd1, 1'b1, 1'b1, 0);

    direct("R7 clr l1", 3'd2, 1'b1, 1'b1, 1);
    direct("R7 clr l2", 3'd4, 1'b1, 1'b1, 2);
    stepped("R7 cleared");

    direct("R9 to l2", 3'd4, 1'b1, 1'b1, 2);
    direct("R9 slow target", 3'd1, 1'b1, 1'b0, 0);
    direct("R9 l1 from l0", 3'd2, 1'b1, 1'b1, 1);
    direct("R9 slow tgt clr", 3'd1, 1'b1, 1'b0, 0);
    direct("R9 l1 slow base", 3'd2, 1'b0, 1'b1, 1);
    stepped("R9 cleared dwell");

    direct("R10 to l3", 3'd5, 1'b0, 1'b1, 3);
    direct("R10 direct l0", 3'd1, 1'b0, 1'b1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule